// File: doc/BRIEF.md
# Protected Clock Command Register

This block keeps the clock-control command path of a chip behind a timed two-write unlock. A single-port register bus (address, byte data, write strobe, combinational read data) reaches two registers. The command register takes an unlock key and then a 4-bit operation code. The selection register holds a clock-out enable, a start-up delay select and a clock-source select. The selection register resets to values taken from static fuse inputs.

After a valid unlock, a write with the top bit clear is accepted. A live operation code then produces a one-cycle command strobe to the clock-switching logic. The strobe carries the code and the selection fields. A source-availability status flag is cleared by the availability request. An external clock-ready input sets it again, so software can tell a source that is still starting up from one that is absent.

Top module: `clk_cmd_guard`

## Requirements
- R1: A command-register write of exactly 0x80 arms the block. A command-register write with bit 7 set and any other bit set does not arm it and cancels an open window.
- R2: A command-register write with bit 7 clear, made in any of the 4 cycles after the arming write, is accepted. For a live code, `cmd_valid` is high for exactly the one cycle after the accepting clock edge, and `cmd_op` carries bits 3:0 of that write.
- R3: A write with bit 7 clear made 5 or more cycles after arming, or made without arming, has no effect. A window closes after one accepted write, so a second write needs a new unlock.
- R4: Live codes are 0001 source off, 0010 source on, 0011 availability request, 0100 source switch, 0101 recover, 0110 watchdog auto-reload, and 0111 clock-out. Code 0000 and every code with bit 3 set are accepted but raise no strobe.
- R5: `cmd_cout`, `cmd_sut` and `cmd_src` carry the selection register as it stood before the accepting edge.
- R6: The selection register is at address 1. Bit 7 reads zero, bit 6 is clock-out, bits 5:4 are start-up select and bits 3:0 are source select. It resets to {~fuse_ckout, fuse_sut, fuse_src}, and a write stores bits 6:0 directly.
- R7: An accepted recover code (0101) reloads selection bits 5:0 from the fuse inputs. It leaves bit 6 unchanged.
- R8: An accepted request code (0011) clears `src_avail`, and this wins over `clk_ready` on that edge. On any other edge, `clk_ready` high sets `src_avail`. The flag is zero after reset.
- R9: The command register is at address 0 and reads as {3'b000, src_avail, last accepted code}. The change-enable bit 7 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 1 | Register select: 0 command, 1 selection |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| fuse_ckout | input | 1 | Static clock-out fuse (inverted into bit 6 at reset) |
| fuse_sut | input | 2 | Static start-up delay fuses |
| fuse_src | input | 4 | Static source-select fuses |
| clk_ready | input | 1 | Selected source reports it is running |
| src_avail | output | 1 | Source availability flag |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Operation code with the strobe |
| cmd_cout | output | 1 | Clock-out field with the strobe |
| cmd_sut | output | 2 | Start-up field with the strobe |
| cmd_src | output | 4 | Source field with the strobe |

## Verification
The bench targets the window edges: a write on the fourth cycle after arming must strobe, and one on the fifth must not. A design off by one would either drop the legal write or let the late one through. A near-miss key such as 0x81 must not arm. Codes 0000 and 1xxx must stay silent even when accepted. A design that strobes on them would fire spurious clock actions. A recover after the clock-out bit has been changed must leave that bit alone, because reloading all of bits 6:0 would wrongly flip the clock output. An availability request issued while `clk_ready` is high must read zero for one cycle. Wrong priority there would hide the request from software.

// File: rtl/clk_cmd_pkg.sv
package clk_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE     = 4'h0,
    OP_SRC_OFF  = 4'h1,
    OP_SRC_ON   = 4'h2,
    OP_SRC_REQ  = 4'h3,
    OP_SWITCH   = 4'h4,
    OP_RECOVER  = 4'h5,
    OP_WDOG     = 4'h6,
    OP_CLKOUT   = 4'h7
  } clk_op_e;

  typedef struct packed {
    logic       cout;
    logic [1:0] sut;
    logic [3:0] src;
  } clk_sel_t;

  localparam int unsigned REG_W   = 8;
  localparam logic [7:0]  ARM_KEY = 8'h80;
  localparam int unsigned KEY_BIT = 7;

endpackage

// File: rtl/clk_cmd_unlock.sv
module clk_cmd_unlock #(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] wdata,
  output logic       armed,
  output logic       accept
);
  import clk_cmd_pkg::*;

  localparam int unsigned CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WIN_CYC);

  logic [CNT_W-1:0] win_q, win_d;
  logic             win_en;

  assign armed  = (win_q != '0);
  assign accept = cmd_wr && armed && !wdata[KEY_BIT];

  always_comb begin
    win_en = 1'b0;
    win_d  = win_q;
    if (cmd_wr) begin
      win_en = 1'b1;
      win_d  = (wdata == ARM_KEY) ? WIN_LOAD : '0;
    end else if (armed) begin
      win_en = 1'b1;
      win_d  = win_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

endmodule

// File: rtl/clk_cmd_decode.sv
module clk_cmd_decode (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic [3:0]            code,
  input  clk_cmd_pkg::clk_sel_t cur_sel,
  output logic                  rec_hit,
  output logic                  req_hit,
  output logic                  cmd_valid,
  output logic [3:0]            cmd_op,
  output clk_cmd_pkg::clk_sel_t cmd_sel,
  output logic [3:0]            last_code
);
  import clk_cmd_pkg::*;

  logic live;
  logic valid_d;

  assign live    = !code[3] && (code != OP_NONE);
  assign valid_d = accept && live;
  assign rec_hit = accept && (code == OP_RECOVER);
  assign req_hit = accept && (code == OP_SRC_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_valid <= 1'b0;
    else        cmd_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_op  <= '0;
      cmd_sel <= '0;
    end else if (valid_d) begin
      cmd_op  <= code;
      cmd_sel <= cur_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_code <= '0;
    else if (accept) last_code <= code;
  end

endmodule

// File: rtl/clk_cmd_selreg.sv
module clk_cmd_selreg (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_wr,
  input  logic [6:0]            wdata,
  input  logic                  rec_hit,
  input  logic                  req_hit,
  input  logic                  clk_ready,
  input  logic                  fuse_ckout,
  input  logic [1:0]            fuse_sut,
  input  logic [3:0]            fuse_src,
  output clk_cmd_pkg::clk_sel_t sel_q,
  output logic                  avail_q
);
  import clk_cmd_pkg::*;

  clk_sel_t sel_d;
  clk_sel_t sel_rst;
  logic     sel_en;
  logic     avail_d;
  logic     avail_en;

  assign sel_rst = '{cout: ~fuse_ckout, sut: fuse_sut, src: fuse_src};

  always_comb begin
    sel_en = 1'b0;
    sel_d  = sel_q;
    if (sel_wr) begin
      sel_en = 1'b1;
      sel_d  = clk_sel_t'(wdata);
    end else if (rec_hit) begin
      sel_en    = 1'b1;
      sel_d.sut = fuse_sut;
      sel_d.src = fuse_src;
    end
  end

  always_comb begin
    avail_en = req_hit || clk_ready;
    avail_d  = !req_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= sel_rst;
    else if (sel_en) sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        avail_q <= 1'b0;
    else if (avail_en) avail_q <= avail_d;
  end

endmodule

// File: rtl/clk_cmd_guard.sv
module clk_cmd_guard #(
  parameter int unsigned WIN_CYC  = 4,
  parameter int unsigned ADDR_W   = 1,
  parameter int unsigned ADDR_CMD = 0,
  parameter int unsigned ADDR_SEL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  input  logic              fuse_ckout,
  input  logic [1:0]        fuse_sut,
  input  logic [3:0]        fuse_src,
  input  logic              clk_ready,
  output logic              src_avail,
  output logic              cmd_valid,
  output logic [3:0]        cmd_op,
  output logic              cmd_cout,
  output logic [1:0]        cmd_sut,
  output logic [3:0]        cmd_src
);
  import clk_cmd_pkg::*;

  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(ADDR_CMD);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(ADDR_SEL);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic       cmd_wr, sel_wr;
  logic       armed, accept;
  logic       rec_hit, req_hit;
  logic [3:0] last_code;
  clk_sel_t   sel_q;
  clk_sel_t   cmd_sel;

  assign cmd_wr = bus_we && (bus_addr == A_CMD);
  assign sel_wr = bus_we && (bus_addr == A_SEL);

  clk_cmd_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cmd_wr (cmd_wr),
    .wdata  (bus_wdata),
    .armed  (armed),
    .accept (accept)
  );

  clk_cmd_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .code      (bus_wdata[3:0]),
    .cur_sel   (sel_q),
    .rec_hit   (rec_hit),
    .req_hit   (req_hit),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_sel   (cmd_sel),
    .last_code (last_code)
  );

  clk_cmd_selreg u_selreg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sel_wr     (sel_wr),
    .wdata      (bus_wdata[6:0]),
    .rec_hit    (rec_hit),
    .req_hit    (req_hit),
    .clk_ready  (clk_ready),
    .fuse_ckout (fuse_ckout),
    .fuse_sut   (fuse_sut),
    .fuse_src   (fuse_src),
    .sel_q      (sel_q),
    .avail_q    (src_avail)
  );

  assign cmd_cout = cmd_sel.cout;
  assign cmd_sut  = cmd_sel.sut;
  assign cmd_src  = cmd_sel.src;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CMD)      bus_rdata = {3'b000, src_avail, last_code};
    else if (bus_addr == A_SEL) bus_rdata = {1'b0, sel_q};
  end

endmodule

// File: rtl/clk_cmd_guard_chk.sv
module clk_cmd_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [7:0] wdata,
  input logic       armed,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       sel_cout,
  input logic [5:0] sel_low,
  input logic [1:0] fuse_sut,
  input logic [3:0] fuse_src,
  input logic       src_avail
);

  a_r1_arm_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(cmd_wr) && ($past(wdata) == 8'h80)));

  a_r2_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cmd_wr && armed && !wdata[7]));

  a_r3_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r4_live_code: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (!cmd_op[3] && (cmd_op != 4'h0)));

  a_r7_recover_keeps_cout: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 4'h5)) |-> ($stable(sel_cout) && (sel_low == {fuse_sut, fuse_src})));

  a_r8_request_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 4'h3)) |-> !src_avail);

endmodule

bind clk_cmd_guard clk_cmd_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_wr    (cmd_wr),
  .wdata     (bus_wdata),
  .armed     (armed),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .sel_cout  (sel_q.cout),
  .sel_low   ({sel_q.sut, sel_q.src}),
  .fuse_sut  (fuse_sut),
  .fuse_src  (fuse_src),
  .src_avail (src_avail)
);

// File: tb/clk_cmd_guard_tb_top.sv
module clk_cmd_guard_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic [7:0] bus_rdata;
  logic       fuse_ckout;
  logic [1:0] fuse_sut;
  logic [3:0] fuse_src;
  logic       clk_ready;
  logic       src_avail;
  logic       cmd_valid;
  logic [3:0] cmd_op;
  logic       cmd_cout;
  logic [1:0] cmd_sut;
  logic [3:0] cmd_src;

  always #2 clk = ~clk;

  clk_cmd_guard dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .fuse_ckout(fuse_ckout),
    .fuse_sut(fuse_sut), .fuse_src(fuse_src), .clk_ready(clk_ready),
    .src_avail(src_avail), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_cout(cmd_cout), .cmd_sut(cmd_sut), .cmd_src(cmd_src)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int         m_cnt;
  logic [3:0] m_last;
  logic [6:0] m_sel;
  logic       m_avail;
  logic       e_valid;
  logic [3:0] e_op;
  logic [6:0] e_fields;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic a);
    return a ? {1'b0, m_sel} : {3'b000, m_avail, m_last};
  endfunction

  task automatic model_step();
    logic acc;
    acc = bus_we && !bus_addr && !bus_wdata[7] && (m_cnt > 0);
    e_valid = acc && (bus_wdata[3:0] != 4'h0) && !bus_wdata[3];
    if (e_valid) begin
      e_op     = bus_wdata[3:0];
      e_fields = m_sel;
    end
    if (acc && bus_wdata[3:0] == 4'h3) m_avail = 1'b0;
    else if (clk_ready)                m_avail = 1'b1;
    if (bus_we && bus_addr) m_sel = bus_wdata[6:0];
    else if (acc && bus_wdata[3:0] == 4'h5) m_sel[5:0] = {fuse_sut, fuse_src};
    if (acc) m_last = bus_wdata[3:0];
    if (bus_we && !bus_addr) m_cnt = (bus_wdata == 8'h80) ? 4 : 0;
    else if (m_cnt > 0)      m_cnt--;
  endtask

  task automatic cyc(input logic w, input logic a, input logic [7:0] d, input logic r);
    @(negedge clk);
    bus_we = w; bus_addr = a; bus_wdata = d; clk_ready = r;
    @(posedge clk);
    model_step();
    #1;
    chk("R2 strobe", cmd_valid, e_valid);
    if (e_valid) begin
      chk("R2 op", cmd_op, e_op);
      chk("R5 fields", {cmd_cout, cmd_sut, cmd_src}, e_fields);
    end
    chk(a ? "R6 selection readback" : "R9 command readback", bus_rdata, exp_rd(a));
    chk("R8 availability", src_avail, m_avail);
  endtask

  task automatic idle(input int n, input logic a, input logic r);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 8'h00, r);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c10c));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 1'b0; bus_wdata = '0; clk_ready = 1'b0;
    fuse_ckout = 1'b0; fuse_sut = 2'b10; fuse_src = 4'b0110;
    m_cnt = 0; m_last = '0; m_sel = {1'b1, 2'b10, 4'b0110}; m_avail = 1'b0;
    e_valid = 1'b0; e_op = '0; e_fields = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(3, 1'b0, 1'b0);

    // reset state
    idle(1, 1'b1, 1'b0);
    chk("R6 reset selection", bus_rdata, 8'h66);
    idle(1, 1'b0, 1'b0);
    chk("R9 reset command", bus_rdata, 8'h00);

    // direct selection write, bit 7 dropped
    cyc(1'b1, 1'b1, 8'h8B, 1'b0);
    chk("R6 selection write", bus_rdata, 8'h0B);

    // recover accepted on the 4th cycle after arming
    cyc(1'b1, 1'b0, 8'h80, 1'b0);
    idle(3, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 8'h05, 1'b0);
    chk("R2 last window cycle strobe", cmd_valid, 1'b1);
    chk("R5 old fields on strobe", {cmd_cout, cmd_sut, cmd_src}, 7'h0B);
    idle(1, 1'b1, 1'b0);
    chk("R7 recover keeps clock-out", bus_rdata, 8'h26);

    // write on the 5th cycle is late
    cyc(1'b1, 1'b0, 8'h80, 1'b0);
    idle(4, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 8'h07, 1'b0);
    chk("R3 late write ignored", cmd_valid, 1'b0);
    chk("R3 last code kept", bus_rdata, 8'h05);

    // second write in one window
    cyc(1'b1, 1'b0, 8'h80, 1'b0);
    cyc(1'b1, 1'b0, 8'h01, 1'b0);
    cyc(1'b1, 1'b0, 8'h02, 1'b0);
    chk("R3 second write ignored", cmd_valid, 1'b0);
    chk("R3 readback after second write", bus_rdata, 8'h01);

    // near-miss key
    cyc(1'b1, 1'b0, 8'h81, 1'b0);
    cyc(1'b1, 1'b0, 8'h02, 1'b0);
    chk("R1 bad key does not arm", cmd_valid, 1'b0);
    cyc(1'b1, 1'b0, 8'h80, 1'b0);
    cyc(1'b1, 1'b0, 8'hC0, 1'b0);
    cyc(1'b1, 1'b0, 8'h02, 1'b0);
    chk("R1 bad key closes window", cmd_valid, 1'b0);

    // silent codes
    cyc(1'b1, 1'b0, 8'h80, 1'b0);
    cyc(1'b1, 1'b0, 8'h0A, 1'b0);
    chk("R4 1xxx silent", cmd_valid, 1'b0);
    chk("R9 last code 1xxx", bus_rdata, 8'h0A);
    cyc(1'b1, 1'b0, 8'h80, 1'b0);
    cyc(1'b1, 1'b0, 8'h00, 1'b0);
    chk("R4 0000 silent", cmd_valid, 1'b0);

    // availability request while ready is high
    idle(2, 1'b0, 1'b1);
    chk("R8 ready sets flag", src_avail, 1'b1);
    cyc(1'b1, 1'b0, 8'h80, 1'b1);
    cyc(1'b1, 1'b0, 8'h03, 1'b1);
    chk("R8 request wins over ready", src_avail, 1'b0);
    chk("R9 readback with flag low", bus_rdata, 8'h03);
    idle(1, 1'b0, 1'b1);
    chk("R8 ready sets again", src_avail, 1'b1);

    // clock-out command
    cyc(1'b1, 1'b1, 8'h40, 1'b0);
    cyc(1'b1, 1'b0, 8'h80, 1'b0);
    cyc(1'b1, 1'b0, 8'h07, 1'b0);
    chk("R4 clock-out op", cmd_op, 4'h7);
    chk("R5 clock-out field", cmd_cout, 1'b1);

    // random traffic
    for (int i = 0; i < 5000; i++) begin
      logic       w, a, r;
      logic [7:0] d;
      int         pick;
      pick = $urandom_range(0, 9);
      w = ($urandom_range(0, 3) != 0);
      a = ($urandom_range(0, 4) == 0);
      r = ($urandom_range(0, 2) == 0);
      if (pick < 3)      d = 8'h80;
      else if (pick < 7) d = 8'($urandom_range(0, 15));
      else               d = 8'($urandom);
      cyc(w, a, d, r);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule